// File: doc/BRIEF.md
# Processor trap entry unit

This unit moves a processor from normal execution into a trap handler. A single-cycle request arrives together with a cause code. The core also supplies its current program counter, status word, exception status word, pending branch target and three instruction-state flags. On the next clock edge the unit presents every write-back the core must perform, each with its own write enable. These write-backs are the handler address, the link register number and its value, the adjusted status word, the exception status word and branch-target register where the cause needs them, and pulses that clear the instruction-state flags and the load reservation.

There are four causes: hardware exception, memory-management fault, external interrupt and hardware break. They differ in the handler offset, the link register used, the return address saved and the status bits touched. Every cause stacks the user-mode and virtual-memory bits into their shadow bits and then clears the live bits. An MMU fault saves a re-execute address that backs up over an immediate prefix or a branch whose delay slot faulted. A hardware exception request is dropped when the exception-support input is low. Cause codes outside the four defined ones raise an error pulse and nothing else.

Top module: `trap_entry_unit`

## Requirements
- R1: `trapCause` encodes 0 = hardware exception, 1 = MMU fault, 2 = external interrupt, 3 = break. An accepted request commits all its write-backs on the first clock edge after the request cycle. `pcNext` is `baseVector` plus 0x20 for causes 0 and 1, plus 0x10 for cause 2, and plus 0x18 for cause 3.
- R2: A hardware exception writes `pc`+4 to link register 17 and sets the exception-in-progress bit (status bit 9).
- R3: An MMU fault writes to link register 17. The value is `pc`-8 when `inDelaySlot` and `immBranch` are both set, `pc`-4 when only `inDelaySlot` is set, `pc`-4 when `immPrefix` is set without `inDelaySlot`, and `pc` otherwise.
- R4: Causes 0 and 1 write the exception status word as `curEsr` with bit 12 equal to `inDelaySlot`. When `inDelaySlot` is set they also write `branchTarget` to the branch-target register. Otherwise `btrWe` stays low.
- R5: An external interrupt writes `pc` to link register 14 and clears the interrupt-enable bit (status bit 1).
- R6: A break writes `pc` to link register 16 and sets the break-in-progress bit (status bit 3).
- R7: Interrupts and breaks leave `esrWe` and `btrWe` low.
- R8: For every accepted cause, status bit 12 takes the old bit 11 (user mode) and bit 14 takes the old bit 13 (virtual memory). Bits 11 and 13 are cleared. Bits not named in R2, R5, R6 or R8 keep their `curStatus` value.
- R9: Every accepted trap pulses `flagClr` and `resvClr` for one cycle, together with `pcWe`, `linkWe` and `statusWe`.
- R10: A cause-0 request while `excSupport` is low produces no write enable, no clear pulse and no error.
- R11: A request with a cause code of 4 to 7 pulses `causeErr` one cycle later and raises no write enable or clear pulse.
- R12: During and right after reset every write enable, clear pulse and `causeErr` is low.
- R13: In a cycle following one without a request, every write enable, clear pulse and `causeErr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | One-cycle trap request |
| trapCause | input | 3 | Cause code |
| excSupport | input | 1 | Hardware exceptions are configured |
| baseVector | input | 32 | Handler base address |
| pc | input | 32 | Current program counter |
| curStatus | input | 32 | Current status word |
| curEsr | input | 32 | Current exception status word |
| branchTarget | input | 32 | Pending branch target |
| inDelaySlot | input | 1 | Trapped instruction sits in a delay slot |
| immPrefix | input | 1 | Trapped instruction follows an immediate prefix |
| immBranch | input | 1 | The pending branch carried an immediate prefix |
| pcWe | output | 1 | Write enable for the new PC |
| pcNext | output | 32 | Handler address |
| linkWe | output | 1 | Link register write enable |
| linkIdx | output | 5 | Link register number |
| linkData | output | 32 | Saved return address |
| statusWe | output | 1 | Status word write enable |
| statusNext | output | 32 | Adjusted status word |
| esrWe | output | 1 | Exception status write enable |
| esrNext | output | 32 | New exception status word |
| btrWe | output | 1 | Branch-target register write enable |
| btrNext | output | 32 | New branch-target value |
| flagClr | output | 1 | Clear the instruction-state flags |
| resvClr | output | 1 | Clear the load reservation |
| causeErr | output | 1 | Unknown cause code was requested |

## Verification
On every cycle the assertions check the following. Commits follow a request by one edge and stay grouped. The live mode bits are always cleared on a status write. The interrupt and break links carry the correct status changes. The exception status and branch-target writes occur only on the exception link. Error pulses never coincide with writes, and a dropped hardware exception never commits. Only the bench's sweep over causes, flag combinations, status patterns and the support input can show the exact return arithmetic, the handler offsets, and the preservation of untouched status and exception status bits.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [2:0] CAUSE_HWEXC = 3'd0;
  localparam logic [2:0] CAUSE_MMU   = 3'd1;
  localparam logic [2:0] CAUSE_IRQ   = 3'd2;
  localparam logic [2:0] CAUSE_BRK   = 3'd3;

  typedef enum logic [1:0] {
    RET_PC,
    RET_PC_PLUS4,
    RET_REEXEC
  } retMode_e;

  typedef struct packed {
    logic     commit;
    logic     err;
    logic     saveEsr;
    logic     setEip;
    logic     setBip;
    logic     clrIe;
    retMode_e retMode;
    logic [4:0] linkIdx;
    logic [7:0] vecOff;
  } trapCtrl_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter logic [4:0] LINK_EXC = 5'd17,
  parameter logic [4:0] LINK_IRQ = 5'd14,
  parameter logic [4:0] LINK_BRK = 5'd16,
  parameter logic [7:0] OFF_EXC  = 8'h20,
  parameter logic [7:0] OFF_IRQ  = 8'h10,
  parameter logic [7:0] OFF_BRK  = 8'h18
) (
  input  logic       trapReq,
  input  logic [2:0] trapCause,
  input  logic       excSupport,
  output trapCtrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.retMode = RET_PC;
    if (trapReq) begin
      unique case (trapCause)
        CAUSE_HWEXC: begin
          ctrl.commit  = excSupport;
          ctrl.saveEsr = 1'b1;
          ctrl.setEip  = 1'b1;
          ctrl.retMode = RET_PC_PLUS4;
          ctrl.linkIdx = LINK_EXC;
          ctrl.vecOff  = OFF_EXC;
        end
        CAUSE_MMU: begin
          ctrl.commit  = 1'b1;
          ctrl.saveEsr = 1'b1;
          ctrl.setEip  = 1'b1;
          ctrl.retMode = RET_REEXEC;
          ctrl.linkIdx = LINK_EXC;
          ctrl.vecOff  = OFF_EXC;
        end
        CAUSE_IRQ: begin
          ctrl.commit  = 1'b1;
          ctrl.clrIe   = 1'b1;
          ctrl.linkIdx = LINK_IRQ;
          ctrl.vecOff  = OFF_IRQ;
        end
        CAUSE_BRK: begin
          ctrl.commit  = 1'b1;
          ctrl.setBip  = 1'b1;
          ctrl.linkIdx = LINK_BRK;
          ctrl.vecOff  = OFF_BRK;
        end
        default: ctrl.err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ESR_W   = 32,
  parameter int DS_BIT  = 12,
  parameter int IE_BIT  = 1,
  parameter int BIP_BIT = 3,
  parameter int EIP_BIT = 9,
  parameter int UM_BIT  = 11,
  parameter int VM_BIT  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  trapCtrl_t        ctrl,
  input  logic [XLEN-1:0]  baseVector,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  curStatus,
  input  logic [ESR_W-1:0] curEsr,
  input  logic [XLEN-1:0]  branchTarget,
  input  logic             inDelaySlot,
  input  logic             immPrefix,
  input  logic             immBranch,
  output logic             pcWe,
  output logic [XLEN-1:0]  pcNext,
  output logic             linkWe,
  output logic [4:0]       linkIdx,
  output logic [XLEN-1:0]  linkData,
  output logic             statusWe,
  output logic [XLEN-1:0]  statusNext,
  output logic             esrWe,
  output logic [ESR_W-1:0] esrNext,
  output logic             btrWe,
  output logic [XLEN-1:0]  btrNext,
  output logic             flagClr,
  output logic             resvClr,
  output logic             causeErr
);
  localparam int UMS_BIT = UM_BIT + 1;
  localparam int VMS_BIT = VM_BIT + 1;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0]  retAddr;
  logic [XLEN-1:0]  statusAdj;
  logic [ESR_W-1:0] esrAdj;

  always_comb begin
    unique case (ctrl.retMode)
      RET_PC_PLUS4: retAddr = pc + STEP;
      RET_REEXEC: begin
        if (inDelaySlot)    retAddr = immBranch ? pc - (STEP << 1) : pc - STEP;
        else if (immPrefix) retAddr = pc - STEP;
        else                retAddr = pc;
      end
      default: retAddr = pc;
    endcase
  end

  always_comb begin
    statusAdj = curStatus;
    if (ctrl.clrIe)  statusAdj[IE_BIT]  = 1'b0;
    if (ctrl.setBip) statusAdj[BIP_BIT] = 1'b1;
    if (ctrl.setEip) statusAdj[EIP_BIT] = 1'b1;
    statusAdj[UMS_BIT] = curStatus[UM_BIT];
    statusAdj[VMS_BIT] = curStatus[VM_BIT];
    statusAdj[UM_BIT]  = 1'b0;
    statusAdj[VM_BIT]  = 1'b0;
  end

  always_comb begin
    esrAdj = curEsr;
    esrAdj[DS_BIT] = inDelaySlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcWe       <= 1'b0;
      pcNext     <= '0;
      linkWe     <= 1'b0;
      linkIdx    <= '0;
      linkData   <= '0;
      statusWe   <= 1'b0;
      statusNext <= '0;
      esrWe      <= 1'b0;
      esrNext    <= '0;
      btrWe      <= 1'b0;
      btrNext    <= '0;
      flagClr    <= 1'b0;
      resvClr    <= 1'b0;
      causeErr   <= 1'b0;
    end else begin
      pcWe     <= ctrl.commit;
      linkWe   <= ctrl.commit;
      statusWe <= ctrl.commit;
      flagClr  <= ctrl.commit;
      resvClr  <= ctrl.commit;
      esrWe    <= ctrl.commit & ctrl.saveEsr;
      btrWe    <= ctrl.commit & ctrl.saveEsr & inDelaySlot;
      causeErr <= ctrl.err;
      if (ctrl.commit) begin
        pcNext     <= baseVector + XLEN'(ctrl.vecOff);
        linkIdx    <= ctrl.linkIdx;
        linkData   <= retAddr;
        statusNext <= statusAdj;
        if (ctrl.saveEsr) esrNext <= esrAdj;
        if (ctrl.saveEsr && inDelaySlot) btrNext <= branchTarget;
      end
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ESR_W   = 32,
  parameter int DS_BIT  = 12,
  parameter int IE_BIT  = 1,
  parameter int BIP_BIT = 3,
  parameter int EIP_BIT = 9,
  parameter int UM_BIT  = 11,
  parameter int VM_BIT  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapReq,
  input  logic [2:0]       trapCause,
  input  logic             excSupport,
  input  logic [XLEN-1:0]  baseVector,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  curStatus,
  input  logic [ESR_W-1:0] curEsr,
  input  logic [XLEN-1:0]  branchTarget,
  input  logic             inDelaySlot,
  input  logic             immPrefix,
  input  logic             immBranch,
  output logic             pcWe,
  output logic [XLEN-1:0]  pcNext,
  output logic             linkWe,
  output logic [4:0]       linkIdx,
  output logic [XLEN-1:0]  linkData,
  output logic             statusWe,
  output logic [XLEN-1:0]  statusNext,
  output logic             esrWe,
  output logic [ESR_W-1:0] esrNext,
  output logic             btrWe,
  output logic [XLEN-1:0]  btrNext,
  output logic             flagClr,
  output logic             resvClr,
  output logic             causeErr
);
  trapCtrl_t ctrl;

  trap_ctrl uCtrl (
    .trapReq    (trapReq),
    .trapCause  (trapCause),
    .excSupport (excSupport),
    .ctrl       (ctrl)
  );

  trap_datapath #(
    .XLEN(XLEN), .ESR_W(ESR_W), .DS_BIT(DS_BIT), .IE_BIT(IE_BIT),
    .BIP_BIT(BIP_BIT), .EIP_BIT(EIP_BIT), .UM_BIT(UM_BIT), .VM_BIT(VM_BIT)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .baseVector(baseVector), .pc(pc), .curStatus(curStatus), .curEsr(curEsr),
    .branchTarget(branchTarget), .inDelaySlot(inDelaySlot),
    .immPrefix(immPrefix), .immBranch(immBranch),
    .pcWe(pcWe), .pcNext(pcNext), .linkWe(linkWe), .linkIdx(linkIdx),
    .linkData(linkData), .statusWe(statusWe), .statusNext(statusNext),
    .esrWe(esrWe), .esrNext(esrNext), .btrWe(btrWe), .btrNext(btrNext),
    .flagClr(flagClr), .resvClr(resvClr), .causeErr(causeErr)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN    = 32,
  parameter int ESR_W   = 32,
  parameter int DS_BIT  = 12,
  parameter int IE_BIT  = 1,
  parameter int BIP_BIT = 3,
  parameter int UM_BIT  = 11,
  parameter int VM_BIT  = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             trapReq,
  input logic [2:0]       trapCause,
  input logic             excSupport,
  input logic             pcWe,
  input logic             linkWe,
  input logic [4:0]       linkIdx,
  input logic             statusWe,
  input logic [XLEN-1:0]  statusNext,
  input logic             esrWe,
  input logic [ESR_W-1:0] esrNext,
  input logic             btrWe,
  input logic             flagClr,
  input logic             resvClr,
  input logic             causeErr
);
  assert_commit_after_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    pcWe |-> $past(trapReq));
  assert_commit_grouped_R9: assert property (@(posedge clk) disable iff (!rstN)
    pcWe |-> (flagClr && resvClr && statusWe && linkWe));
  assert_mode_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> (!statusNext[UM_BIT] && !statusNext[VM_BIT]));
  assert_irq_ie_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (linkWe && linkIdx == 5'd14) |-> !statusNext[IE_BIT]);
  assert_brk_bip_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (linkWe && linkIdx == 5'd16) |-> statusNext[BIP_BIT]);
  assert_esr_on_exc_link_R7: assert property (@(posedge clk) disable iff (!rstN)
    esrWe |-> (linkWe && linkIdx == 5'd17));
  assert_btr_needs_ds_R4: assert property (@(posedge clk) disable iff (!rstN)
    btrWe |-> (esrWe && esrNext[DS_BIT]));
  assert_err_no_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    causeErr |-> (!pcWe && !esrWe && !flagClr));
  assert_unsupported_dropped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pcWe && $past(trapCause) == 3'd0) |-> $past(excSupport));
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    !$past(trapReq) |-> !(pcWe || causeErr || flagClr));
endmodule

bind trap_entry_unit trap_entry_chk #(
  .XLEN(XLEN), .ESR_W(ESR_W), .DS_BIT(DS_BIT), .IE_BIT(IE_BIT),
  .BIP_BIT(BIP_BIT), .UM_BIT(UM_BIT), .VM_BIT(VM_BIT)
) uChk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapCause(trapCause),
  .excSupport(excSupport), .pcWe(pcWe), .linkWe(linkWe), .linkIdx(linkIdx),
  .statusWe(statusWe), .statusNext(statusNext), .esrWe(esrWe),
  .esrNext(esrNext), .btrWe(btrWe), .flagClr(flagClr), .resvClr(resvClr),
  .causeErr(causeErr)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [2:0]  trapCause = '0;
  logic        excSupport = 1'b0;
  logic [31:0] baseVector = '0, pc = '0, curStatus = '0, curEsr = '0, branchTarget = '0;
  logic        inDelaySlot = 1'b0, immPrefix = 1'b0, immBranch = 1'b0;
  logic        pcWe, linkWe, statusWe, esrWe, btrWe, flagClr, resvClr, causeErr;
  logic [31:0] pcNext, linkData, statusNext, esrNext, btrNext;
  logic [4:0]  linkIdx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_entry_unit dut (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapCause(trapCause),
    .excSupport(excSupport), .baseVector(baseVector), .pc(pc),
    .curStatus(curStatus), .curEsr(curEsr), .branchTarget(branchTarget),
    .inDelaySlot(inDelaySlot), .immPrefix(immPrefix), .immBranch(immBranch),
    .pcWe(pcWe), .pcNext(pcNext), .linkWe(linkWe), .linkIdx(linkIdx),
    .linkData(linkData), .statusWe(statusWe), .statusNext(statusNext),
    .esrWe(esrWe), .esrNext(esrNext), .btrWe(btrWe), .btrNext(btrNext),
    .flagClr(flagClr), .resvClr(resvClr), .causeErr(causeErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] strobes();
    return {pcWe, linkWe, statusWe, esrWe, btrWe, flagClr, resvClr, causeErr};
  endfunction

  task automatic runTrial(input logic [2:0] cause, input logic [2:0] fl,
                          input bit sup, input logic [31:0] st, input int n);
    bit accepted, isExc, ds;
    logic [31:0] expPc, expLink, expSt, expEsr;
    logic [4:0]  expIdx;
    @(negedge clk);
    trapReq = 1'b1; trapCause = cause; excSupport = sup;
    baseVector = 32'h0004_0000 + 32'(n) * 32'h100;
    pc = 32'h0000_2000 + 32'(n) * 12;
    curStatus = st; curEsr = 32'hA5A5_0000 ^ 32'(n) ^ {19'b0, n[0], 12'b0};
    branchTarget = 32'hB000_0000 + 32'(n);
    inDelaySlot = fl[0]; immPrefix = fl[1]; immBranch = fl[2];
    ds = fl[0];
    isExc = (cause == 3'd0) || (cause == 3'd1);
    accepted = (cause <= 3'd3) && !(cause == 3'd0 && !sup);
    expPc = baseVector + (isExc ? 32'h20 : (cause == 3'd2 ? 32'h10 : 32'h18));
    expIdx = isExc ? 5'd17 : (cause == 3'd2 ? 5'd14 : 5'd16);
    if (cause == 3'd0) expLink = pc + 4;
    else if (cause == 3'd1) expLink = ds ? (fl[2] ? pc - 8 : pc - 4) : (fl[1] ? pc - 4 : pc);
    else expLink = pc;
    expSt = st;
    if (isExc) expSt[9] = 1'b1;
    if (cause == 3'd2) expSt[1] = 1'b0;
    if (cause == 3'd3) expSt[3] = 1'b1;
    expSt[12] = st[11]; expSt[14] = st[13]; expSt[11] = 1'b0; expSt[13] = 1'b0;
    expEsr = curEsr; expEsr[12] = ds;
    @(negedge clk);
    trapReq = 1'b0;
    if (cause > 3'd3) begin
      chk("R11 strobes on unknown cause", 32'(strobes()), 32'h01);
    end else if (!accepted) begin
      chk("R10 dropped exception strobes", 32'(strobes()), 32'h00);
    end else begin
      chk("R9 clear pulses", {30'b0, flagClr, resvClr}, 32'h3);
      chk("R1 handler address", pcNext, expPc);
      chk("R1 write enables", {29'b0, pcWe, linkWe, statusWe}, 32'h7);
      chk("R11 no error", 32'(causeErr), 32'h0);
      chk(cause == 3'd0 ? "R2 link number" : cause == 3'd1 ? "R3 link number" :
          cause == 3'd2 ? "R5 link number" : "R6 link number", 32'(linkIdx), 32'(expIdx));
      chk(cause == 3'd0 ? "R2 link value" : cause == 3'd1 ? "R3 link value" :
          cause == 3'd2 ? "R5 link value" : "R6 link value", linkData, expLink);
      chk("R8 status word", statusNext, expSt);
      if (isExc) begin
        chk("R4 esr write", {31'b0, esrWe}, 32'h1);
        chk("R4 esr value", esrNext, expEsr);
        chk("R4 btr write", {31'b0, btrWe}, 32'(ds));
        if (ds) chk("R4 btr value", btrNext, branchTarget);
      end else begin
        chk("R7 esr and btr untouched", {30'b0, esrWe, btrWe}, 32'h0);
      end
    end
    @(negedge clk);
    chk("R13 idle after trial", 32'(strobes()), 32'h00);
  endtask

  initial begin
    logic [31:0] stPat [3];
    stPat[0] = 32'h0000_2802;
    stPat[1] = 32'h0000_0000;
    stPat[2] = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    chk("R12 strobes in reset", 32'(strobes()), 32'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 strobes after reset", 32'(strobes()), 32'h00);
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 8; f++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 3; p++)
            runTrial(3'(c), 3'(f), s[0], stPat[p] ^ (32'(f) << 20), c * 48 + f * 6 + s * 3 + p);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule